// File: doc/BRIEF.md
# Flash Read Checksum Calibration Engine

This block walks a region of flash through a word-wide memory read port and folds every 32-bit word it receives into a running 32-bit sum. Firmware uses the sum to judge whether reads are intact. It takes a baseline sum at a slow, safe clock. It then repeats the same sweep at faster clock divisors and with different input sampling delays, and compares each result against the baseline.

Software programs a start address and a byte length, then writes a start command to the control register. If the calibration bit is set in that command, the clock-divisor code and sampling-delay code embedded in the same write are driven to the read path for the whole sweep. These codes replace the live settings. When the last word has been added, a done flag is raised in the status register and on an interrupt line. Software polls the flag, reads the sum and clears the flag by writing zero. Writing zero to the control register abandons a sweep in flight.

Top module: `calsum_engine`

## Requirements
- R1: After reset no read is requested, done_irq is low, the calibration outputs are zero and every register reads zero.
- R2: A sweep starts only on a control write (byte offset 0x00) with bit 0 (enable) set, bit 2 (checksum) set and bit 1 (write direction) clear, made while idle. Any other control write starts nothing.
- R3: A sweep reads len/4 words, rounded down, from consecutive word addresses that begin at the start address (offset 0x08) and step by 4. Only one read is outstanding at a time. mem_req and mem_addr hold steady until mem_gnt is seen, and the next request follows the returned data (mem_rvalid).
- R4: The checksum register (offset 0x10, read-only) is zeroed at start, equals the modulo 2^32 sum of the words returned, and stays unchanged from the end of a sweep until the next start.
- R5: While a sweep started with control bit 3 (calibration) is running, cal_active is 1, cal_clk_div equals control bits [7:4] and cal_delay equals control bits [11:8]. At every other time all three outputs are zero.
- R6: In the cycle after the final word is accepted, status bit 11 (offset 0x04) and done_irq go high. They stay high until a status write with bit 11 clear, or until a new start.
- R7: A sweep whose length is below 4 bytes issues no read, sets done one cycle after the start write and leaves the checksum at zero.
- R8: A control write of zero during a sweep stops it. No further request is issued, done stays low and data returned late is not added.
- R9: A nonzero control write during a sweep is ignored. The control register, the override outputs and the sweep itself are unchanged.
- R10: The control register (12 bits), start address and length registers read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Flash word read request |
| mem_addr | output | FA_W (28) | Flash byte address of the requested word |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done_irq | output | 1 | Sweep-complete flag |
| cal_active | output | 1 | Override values in force |
| cal_clk_div | output | 4 | Clock-divisor override code |
| cal_delay | output | 4 | Input sampling-delay override code |

## Verification
A wrong word counter or address register shows up on mem_req or mem_addr within one clock of the next grant. It also shows later as a wrong checksum readback. A wrong state (busy left set, a lost abort or a missed completion) shows in the same cycle on cal_active, mem_req or done_irq. For that reason the reference model is compared on those ports every clock, and the sum is compared at the end of each sweep. Corner cases covered are rounding of the length, zero-length and aborted sweeps, starts that are ignored, and late data after an abort.

// File: rtl/calsum_pkg.sv
package calsum_pkg;
  // register word index (byte offset / 4)
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_BASE = 3'd2;
  localparam logic [2:0] IDX_LEN  = 3'd3;
  localparam logic [2:0] IDX_SUM  = 3'd4;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_SUM  = 2;
  localparam int CB_CAL  = 3;
  localparam int CB_DIV  = 4;
  localparam int CB_DLY  = 8;

  // status bit position
  localparam int SB_DONE = 11;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/calsum_csr.sv
module calsum_csr #(
  parameter int FA_W   = 28,
  parameter int LEN_W  = 20,
  parameter int CTRL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic [31:0]       sum,
  output logic [CTRL_W-1:0] ctrl,
  output logic [FA_W-1:0]   base,
  output logic [LEN_W-1:0]  len,
  output logic              done,
  output logic              start,
  output logic              abort
);
  import calsum_pkg::*;

  logic [2:0]        idx;
  logic              wr_ctrl, wr_stat, wr_base, wr_len, wr_zero;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;
  logic              done_d;

  assign idx     = reg_addr[4:2];
  assign wr_ctrl = reg_wr && (idx == IDX_CTRL);
  assign wr_stat = reg_wr && (idx == IDX_STAT);
  assign wr_base = reg_wr && (idx == IDX_BASE);
  assign wr_len  = reg_wr && (idx == IDX_LEN);
  assign wr_zero = (reg_wdata == 32'd0);

  assign start = wr_ctrl && !busy && reg_wdata[CB_EN] && reg_wdata[CB_SUM]
                 && !reg_wdata[CB_DIR];
  assign abort = wr_ctrl && busy && wr_zero;

  always_comb begin
    ctrl_en = wr_ctrl && (!busy || wr_zero);
    ctrl_d  = reg_wdata[CTRL_W-1:0];
  end

  always_comb begin
    done_d = done;
    if (wr_stat && !reg_wdata[SB_DONE]) done_d = 1'b0;
    if (start) done_d = 1'b0;
    if (fin)   done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      base <= '0;
      len  <= '0;
      done <= 1'b0;
    end else begin
      if (ctrl_en) ctrl <= ctrl_d;
      if (wr_base) base <= reg_wdata[FA_W-1:0];
      if (wr_len)  len  <= reg_wdata[LEN_W-1:0];
      done <= done_d;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (idx)
      IDX_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      IDX_STAT: reg_rdata[SB_DONE]    = done;
      IDX_BASE: reg_rdata[FA_W-1:0]   = base;
      IDX_LEN:  reg_rdata[LEN_W-1:0]  = len;
      IDX_SUM:  reg_rdata             = sum;
      default:  reg_rdata             = 32'd0;
    endcase
  end

  AST_BUSY_NO_CTRL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && !wr_zero) |=> $stable(ctrl)); // R9
endmodule

// File: rtl/calsum_seq.sv
module calsum_seq #(
  parameter int FA_W  = 28,
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [FA_W-1:0]  base,
  input  logic [CNT_W-1:0] words,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  output logic             mem_req,
  output logic [FA_W-1:0]  mem_addr,
  output logic             busy,
  output logic             fin,
  output logic             acc_clr,
  output logic             acc_en
);
  import calsum_pkg::*;

  localparam logic [FA_W-1:0]  STEP = FA_W'(4);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  sq_state_e        st_q, st_d;
  logic [FA_W-1:0]  addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    fin    = 1'b0;
    acc_en = 1'b0;
    if (abort) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          addr_d = base;
          left_d = words;
          if (words == '0) fin  = 1'b1;
          else             st_d = SQ_REQ;
        end
        SQ_REQ:  if (mem_gnt) st_d = SQ_WAIT;
        SQ_WAIT: if (mem_rvalid) begin
          acc_en = 1'b1;
          addr_d = addr_q + STEP;
          left_d = left_q - ONE;
          if (left_q == ONE) begin
            st_d = SQ_IDLE;
            fin  = 1'b1;
          end else begin
            st_d = SQ_REQ;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign mem_req  = (st_q == SQ_REQ);
  assign mem_addr = addr_q;
  assign acc_clr  = start;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort) |=> (mem_req && $stable(mem_addr))); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_req && !busy)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (words == '0)) |=> !busy); // R7
endmodule

// File: rtl/calsum_accum.sv
module calsum_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] sum_d;
  logic          sum_ce;

  assign sum_ce = clr || en;

  always_comb begin
    if (clr) sum_d = '0;
    else     sum_d = sum + din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (sum_ce) sum <= sum_d;
  end

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(sum)); // R4
endmodule

// File: rtl/calsum_engine.sv
module calsum_engine #(
  parameter int FA_W  = 28,
  parameter int LEN_W = 20,
  parameter int DIV_W = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic [FA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             done_irq,
  output logic             cal_active,
  output logic [DIV_W-1:0] cal_clk_div,
  output logic [DLY_W-1:0] cal_delay
);
  import calsum_pkg::*;

  localparam int CTRL_W = CB_DLY + DLY_W;
  localparam int CNT_W  = LEN_W - 2;

  logic              rst_meta, srst_n;
  logic              busy, fin, start, abort, acc_clr, acc_en;
  logic [31:0]       sum;
  logic [CTRL_W-1:0] ctrl;
  logic [FA_W-1:0]   base;
  logic [LEN_W-1:0]  len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  calsum_csr #(.FA_W(FA_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W)) u_csr (
    .clk(clk), .rst_n(srst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(busy), .fin(fin), .sum(sum),
    .ctrl(ctrl), .base(base), .len(len), .done(done_irq),
    .start(start), .abort(abort)
  );

  calsum_seq #(.FA_W(FA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(srst_n),
    .start(start), .abort(abort), .base(base), .words(len[LEN_W-1:2]),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .fin(fin), .acc_clr(acc_clr), .acc_en(acc_en)
  );

  calsum_accum #(.DW(32)) u_acc (
    .clk(clk), .rst_n(srst_n),
    .clr(acc_clr), .en(acc_en), .din(mem_rdata), .sum(sum)
  );

  assign cal_active  = busy && ctrl[CB_CAL];
  assign cal_clk_div = cal_active ? ctrl[CB_DIV +: DIV_W] : '0;
  assign cal_delay   = cal_active ? ctrl[CB_DLY +: DLY_W] : '0;

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    done_irq |-> !mem_req); // R6
  AST_OVERRIDE_STEADY: assert property (@(posedge clk) disable iff (!srst_n)
    (cal_active && $past(cal_active)) |-> ($stable(cal_clk_div) && $stable(cal_delay))); // R5
endmodule

// File: tb/calsum_engine_bench.sv
module calsum_engine_bench;
  localparam int FA_W = 28;

  logic            clk, rst_n;
  logic            reg_wr;
  logic [4:0]      reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            mem_req, mem_gnt, mem_rvalid;
  logic [FA_W-1:0] mem_addr;
  logic [31:0]     mem_rdata;
  logic            done_irq, cal_active;
  logic [3:0]      cal_clk_div, cal_delay;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  calsum_engine u_calsum_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done_irq(done_irq), .cal_active(cal_active),
    .cal_clk_div(cal_clk_div), .cal_delay(cal_delay)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  function automatic logic [31:0] memf(input logic [FA_W-1:0] a);
    logic [31:0] x;
    x = {4'h0, a} * 32'h9E3779B1;
    return x ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] golden(input logic [FA_W-1:0] b, input int len);
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < len / 4; i++) s = s + memf(b + FA_W'(4 * i));
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  bit pend = 0;
  int lat = 0, gap = 0, k = 0;
  logic [FA_W-1:0] paddr;
  always @(negedge clk) begin
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    mem_rdata  = 32'd0;
    if (pend) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(paddr);
        pend = 0;
      end else lat--;
    end else if (mem_req === 1'b1) begin
      if (gap == 0) begin
        mem_gnt = 1'b1;
        pend  = 1;
        paddr = mem_addr;
        lat   = k % 3;
        k++;
        gap   = k % 2;
      end else gap--;
    end
  end

  // behavioural reference model
  bit              m_busy = 0, m_out = 0, m_done = 0;
  logic [FA_W-1:0] m_addr = 0, m_base = 0;
  int              m_left = 0, m_len = 0;
  logic [31:0]     m_sum = 0;
  logic [11:0]     m_ctrl = 0;
  always @(posedge clk) begin
    bit st, ab;
    st = 0; ab = 0;
    if (rst_n && reg_wr) begin
      case (reg_addr[4:2])
        3'd0: if (m_busy) begin
                if (reg_wdata == 0) begin ab = 1; m_ctrl = 0; end
              end else begin
                m_ctrl = reg_wdata[11:0];
                if (reg_wdata[0] && reg_wdata[2] && !reg_wdata[1]) st = 1;
              end
        3'd1: if (!reg_wdata[11]) m_done = 0;
        3'd2: m_base = reg_wdata[FA_W-1:0];
        3'd3: m_len = int'(reg_wdata[19:0]);
        default: ;
      endcase
    end
    if (ab) begin
      m_busy = 0; m_out = 0;
    end else if (m_busy) begin
      if (!m_out && mem_gnt) m_out = 1;
      else if (m_out && mem_rvalid) begin
        m_sum = m_sum + mem_rdata;
        m_addr = m_addr + 4;
        m_left--;
        m_out = 0;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
    if (st) begin
      m_sum = 0; m_addr = m_base; m_left = m_len / 4; m_out = 0;
      m_busy = (m_left != 0);
      m_done = (m_left == 0);
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      bit ea;
      ea = m_busy && m_ctrl[3];
      check("R6 done_irq", {31'd0, done_irq}, {31'd0, m_done});
      check("R3 mem_req", {31'd0, mem_req}, {31'd0, m_busy && !m_out});
      if (m_busy && !m_out) check("R3 mem_addr", {4'd0, mem_addr}, {4'd0, m_addr});
      check("R5 cal_active", {31'd0, cal_active}, {31'd0, ea});
      check("R5 cal_clk_div", {28'd0, cal_clk_div}, {28'd0, ea ? m_ctrl[7:4] : 4'd0});
      check("R5 cal_delay", {28'd0, cal_delay}, {28'd0, ea ? m_ctrl[11:8] : 4'd0});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (done_irq !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    check("R6 done reached", {31'd0, done_irq}, 32'd1);
  endtask

  task automatic wait_quiet();
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 done_irq", {31'd0, done_irq}, 32'd0);
    check("R1 cal_active", {31'd0, cal_active}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(5'(i * 4), v);
      check("R1 register zero", v, 32'd0);
    end

    // R10 readback, R3/R4 plain sweep of 0x400 bytes
    wr(5'h08, 32'h0000_1000);
    wr(5'h0C, 32'h0000_0400);
    rd(5'h08, v); check("R10 base readback", v, 32'h1000);
    rd(5'h0C, v); check("R10 len readback", v, 32'h400);
    wr(5'h00, 32'h5);
    wait_done();
    rd(5'h10, v); check("R4 sum 0x400 bytes", v, golden(28'h1000, 'h400));
    rd(5'h04, v); check("R6 status bit 11", v, 32'h800);
    rd(5'h00, v); check("R10 ctrl readback", v, 32'h5);

    // R6 status write with bit 11 set keeps done; write zero clears
    wr(5'h04, 32'h800);
    check("R6 done kept", {31'd0, done_irq}, 32'd1);
    wr(5'h04, 32'h0);
    rd(5'h04, v); check("R6 status cleared", v, 32'h0);
    rd(5'h10, v); check("R4 sum held after clear", v, golden(28'h1000, 'h400));

    // R5 calibration sweep, R3 length rounding (0x23 -> 8 words)
    wr(5'h08, 32'h0002_0040);
    wr(5'h0C, 32'h23);
    wr(5'h00, 32'hB7D);
    rd(5'h00, v); check("R5 ctrl readback", v, 32'hB7D);
    wait_done();
    rd(5'h10, v); check("R3 rounded length sum", v, golden(28'h20040, 'h20));

    // R2 no start with write-direction bit or without checksum bit
    wr(5'h04, 32'h0);
    wr(5'h00, 32'h7);
    wait_quiet();
    check("R2 dir bit no start", {31'd0, mem_req | done_irq}, 32'd0);
    wr(5'h00, 32'h1);
    wait_quiet();
    check("R2 no checksum bit no start", {31'd0, mem_req | done_irq}, 32'd0);
    rd(5'h10, v); check("R2 sum untouched", v, golden(28'h20040, 'h20));

    // R7 zero-length sweep
    wr(5'h0C, 32'h3);
    wr(5'h00, 32'h5);
    check("R7 done immediately", {31'd0, done_irq}, 32'd1);
    rd(5'h10, v); check("R7 sum zero", v, 32'd0);

    // R9 nonzero control write during sweep ignored
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0000_3000);
    wr(5'h0C, 32'h100);
    wr(5'h00, 32'h35D);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'hFFD);
    rd(5'h00, v); check("R9 ctrl unchanged", v, 32'h35D);
    check("R9 override unchanged", {28'd0, cal_clk_div}, 32'h5);
    wait_done();
    rd(5'h10, v); check("R9 sum unaffected", v, golden(28'h3000, 'h100));

    // R8 abort mid-sweep
    wr(5'h04, 32'h0);
    wr(5'h0C, 32'h400);
    wr(5'h00, 32'h5);
    repeat (20) @(negedge clk);
    wr(5'h00, 32'h0);
    wait_quiet();
    check("R8 no request", {31'd0, mem_req}, 32'd0);
    check("R8 no done", {31'd0, done_irq}, 32'd0);
    rd(5'h10, v); check("R8 partial sum, late data dropped", v, m_sum);
    rd(5'h00, v); check("R8 ctrl zero", v, 32'd0);

    // restart after abort works
    wr(5'h0C, 32'h40);
    wr(5'h00, 32'h5);
    wait_done();
    rd(5'h10, v); check("R4 sum after restart", v, golden(28'h3000, 'h40));

    cmp_on = 0;
    finish_run();
  end
endmodule